// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital read-out side of a 14-bit sampling converter. A falling edge on the active-low convert-start input launches a modelled conversion. The block raises a busy flag for a fixed number of system clock cycles and then captures the word on a parallel result input, which stands in for the converter core. The captured value sits in a 16-bit output frame: two zero bits lead, then the 14-bit result, most significant bit first.

A host acting as serial master reads the frame by toggling a serial clock. Each rising edge of that clock places the next frame bit on the data line, so the host can sample it on the falling edge that follows. An internal edge counter selects the frame bit. Because the serial clock may pause at any point, the frame can be read in several bursts.

The edge counter, and the frame with it, are cleared by a convert-start falling edge only when the serial clock is low at that moment. If the host raises the convert-start edge while the serial clock is high, the counter keeps its position. The serial clock and convert-start are brought into the system clock domain through flop-chain synchronisers, and their edges are detected there.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, busy is low and the serial data output is low.
- R2: A convert-start falling edge seen while idle raises busy, and busy stays high for exactly CONV_CYCLES system clock cycles (default 1000, i.e. 5 µs at 200 MHz).
- R3: A further convert-start falling edge during a conversion neither restarts nor lengthens it: busy still lasts CONV_CYCLES cycles from the first edge.
- R4: When busy falls, the frame is loaded with bits [15:14] = 0 and bits [13:0] = the parallel result input at that moment.
- R5: After the k-th serial clock rising edge since the counter was cleared (k = 1..16), the data output carries frame bit 16-k. The first two bits read are therefore zero, followed by result bit 13 down to bit 0.
- R6: The serial clock may stop between bits for any time. A frame read as two 8-bit bursts separated by a pause gives the same 16 bits as a continuous read.
- R7: Every serial clock rising edge after the 16th drives the data output to 0, until the counter is next cleared.
- R8: A convert-start falling edge while the serial clock is low clears the edge counter and the frame, so the data output goes to 0 at once. The next frame is then read from its first bit.
- R9: A convert-start falling edge while the serial clock is high leaves the edge counter unchanged. Reading of the next frame resumes at the bit position where the counter stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Convert-start strobe; its falling edge starts a conversion |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| core_result | input | RES_W | Parallel result from the converter core |
| busy | output | 1 | High while a conversion is in progress |
| sdata | output | 1 | Serial frame data, updated after serial clock rising edges |

## Verification
The assertions check four properties on every cycle. Busy never stays high longer than the conversion length and, when it falls, has lasted exactly that long. The frame holds two zeros above the captured result after each load. The edge counter never passes 16, and edges beyond it give zero. A start with the serial clock low leaves the counter and data output cleared. The bench's scenarios are needed to show the bit order seen from the pins, reads split across a pause, a retriggered start that fails to lengthen busy, and a start with the serial clock high that keeps the read position across a new conversion.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_RUN  = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic conv_prev;
        logic sclk_prev;
    } edge_state_t;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{INIT}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_sp_timer.sv
module adc_sp_timer
    import adc_sp_pkg::*;
#(
    parameter int CONV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic load_o
);
    localparam int TMR_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam int RUN_W = TMR_W + 1;

    typedef struct packed {
        conv_state_e       st;
        logic [TMR_W-1:0]  tmr;
    } tmr_state_t;

    tmr_state_t d, q;

    always_comb begin
        d      = q;
        load_o = 1'b0;
        case (q.st)
            CONV_IDLE: begin
                if (start_i) begin
                    d.st  = CONV_RUN;
                    d.tmr = TMR_W'(CONV_CYCLES - 1);
                end
            end
            default: begin
                if (q.tmr == '0) begin
                    d.st   = CONV_IDLE;
                    load_o = 1'b1;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CONV_IDLE, tmr: '0};
        else        q <= d;
    end

    assign busy_o = (q.st == CONV_RUN);

    // Checker: cycles busy has been high in the current run
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < RUN_W'(CONV_CYCLES)));

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(run_q) == RUN_W'(CONV_CYCLES - 1)));
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
    parameter int RES_W  = 14,
    parameter int LEAD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic             rise_i,
    input  logic [RES_W-1:0] result_i,
    output logic             sdata_o
);
    localparam int FRAME_W = RES_W + LEAD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   cnt;
        logic               sdata;
    } shf_state_t;

    shf_state_t d, q;
    logic [CNT_W-1:0] rev;
    logic [IDX_W-1:0] pos;

    always_comb begin
        d   = q;
        rev = CNT_W'(FRAME_W - 1) - q.cnt;
        pos = rev[IDX_W-1:0];
        if (rise_i) begin
            if (q.cnt < CNT_W'(FRAME_W)) begin
                d.sdata = q.frame[pos];
                d.cnt   = q.cnt + 1'b1;
            end else begin
                d.sdata = 1'b0;
            end
        end
        if (clear_i) begin
            d.cnt   = '0;
            d.frame = '0;
            d.sdata = 1'b0;
        end
        if (load_i) begin
            d.frame = {{LEAD_W{1'b0}}, result_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{frame: '0, cnt: '0, sdata: 1'b0};
        else        q <= d;
    end

    assign sdata_o = q.sdata;

    p_load_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.frame[RES_W-1:0] == $past(result_i)) &&
                   (q.frame[FRAME_W-1:RES_W] == '0));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_W));

    p_overrun_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !clear_i && q.cnt == CNT_W'(FRAME_W)) |=> !q.sdata);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (q.cnt == '0) && !q.sdata);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int LEAD_W      = 2,
    parameter int CONV_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] core_result,
    output logic             busy,
    output logic             sdata
);
    localparam int         N_SYNC    = 2;
    localparam logic [1:0] SYNC_INIT = 2'b10; // [1] convert-start idles high

    logic [N_SYNC-1:0] raw_in, sync_out;
    assign raw_in = {conv_start_n, sclk};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        adc_sp_sync #(
            .STAGES (SYNC_STAGES),
            .INIT   (SYNC_INIT[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[g]),
            .q     (sync_out[g])
        );
    end

    logic conv_s, sclk_s;
    assign conv_s = sync_out[1];
    assign sclk_s = sync_out[0];

    edge_state_t ed_d, ed_q;
    logic start_fall, sclk_rise, cnt_clear, load;

    always_comb begin
        ed_d.conv_prev = conv_s;
        ed_d.sclk_prev = sclk_s;
        start_fall     = ed_q.conv_prev & ~conv_s;
        sclk_rise      = sclk_s & ~ed_q.sclk_prev;
        cnt_clear      = start_fall & ~sclk_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '{conv_prev: 1'b1, sclk_prev: 1'b0};
        else        ed_q <= ed_d;
    end

    adc_sp_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_fall),
        .busy_o  (busy),
        .load_o  (load)
    );

    adc_sp_shifter #(
        .RES_W  (RES_W),
        .LEAD_W (LEAD_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cnt_clear),
        .load_i   (load),
        .rise_i   (sclk_rise),
        .result_i (core_result),
        .sdata_o  (sdata)
    );

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && !busy) |=> busy);
endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
    localparam int RES_W = 14;
    localparam int CONV  = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start_n = 1'b1;
    logic sclk = 1'b0;
    logic [RES_W-1:0] core_result = '0;
    logic busy, sdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.CONV_CYCLES(CONV)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_n (conv_start_n),
        .sclk         (sclk),
        .core_result  (core_result),
        .busy         (busy),
        .sdata        (sdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_of(input logic [RES_W-1:0] r);
        return {16'h0, 2'b00, r};
    endfunction

    task automatic read_bits(input int n, output logic [31:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            w = {w[30:0], sdata};
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic start_conv();
        @(negedge clk);
        conv_start_n = 1'b0;
        repeat (4) @(negedge clk);
        conv_start_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Drive a conversion and count busy-high cycles; optionally retrigger mid-way
    task automatic run_conv(input bit retrig, output int cycles);
        cycles = 0;
        @(negedge clk);
        conv_start_n = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i == 6) conv_start_n = 1'b1;
            if (retrig && i == 300) conv_start_n = 1'b0;
            if (retrig && i == 306) conv_start_n = 1'b1;
            if (busy) cycles++;
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
        chk(sdata == 1'b0, "R1 sdata after reset", 32'(sdata), 0);
    endtask

    task automatic t_length_and_order();
        int cyc;
        logic [31:0] w;
        core_result = 14'h2A5C;
        run_conv(1'b0, cyc);
        chk(cyc == CONV, "R2 busy length", 32'(cyc), 32'(CONV));
        read_bits(2, w);
        chk(w == 0, "R5 two leading zeros", w, 0);
        read_bits(14, w);
        chk(w == 32'h2A5C, "R4 R5 result bits msb first", w, 32'h2A5C);
    endtask

    task automatic t_retrigger();
        int cyc;
        logic [31:0] w;
        core_result = 14'h1234;
        run_conv(1'b1, cyc);
        chk(cyc == CONV, "R3 retrigger does not extend busy", 32'(cyc), 32'(CONV));
        read_bits(16, w);
        chk(w == frame_of(14'h1234), "R3 frame after retrigger", w, frame_of(14'h1234));
    endtask

    task automatic t_bursts();
        logic [31:0] hi, lo, w;
        core_result = 14'h3FFF;
        start_conv();
        wait_idle();
        read_bits(8, hi);
        repeat (50) @(negedge clk);
        read_bits(8, lo);
        w = {hi[23:0], lo[7:0]};
        chk(w == frame_of(14'h3FFF), "R6 two byte bursts", w, frame_of(14'h3FFF));
        // R7: edges past the 16th
        for (int i = 0; i < 3; i++) begin
            read_bits(1, w);
            chk(w == 0, "R7 bit after 16th edge", w, 0);
        end
    endtask

    task automatic t_clear_low();
        logic [31:0] w;
        core_result = 14'h1555;
        start_conv();
        wait_idle();
        read_bits(6, w);
        chk(w == 32'h05, "R5 partial read", w, 32'h05);
        core_result = 14'h0AAA;
        start_conv();
        chk(sdata == 1'b0, "R8 sdata cleared by start", 32'(sdata), 0);
        wait_idle();
        read_bits(16, w);
        chk(w == frame_of(14'h0AAA), "R8 full frame after clear", w, frame_of(14'h0AAA));
    endtask

    task automatic t_no_clear_high();
        logic [31:0] w;
        core_result = 14'h0F0F;
        start_conv();
        wait_idle();
        read_bits(5, w);
        // sixth rising edge; keep the serial clock high across the start edge
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdata == 1'b1, "R9 sixth bit before start", 32'(sdata), 1);
        core_result = 14'h3C3A;
        start_conv();
        chk(sdata == 1'b1, "R9 sdata kept with sclk high", 32'(sdata), 1);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        wait_idle();
        read_bits(10, w);
        chk(w == (frame_of(14'h3C3A) & 32'h3FF), "R9 read resumes at bit 9", w,
            frame_of(14'h3C3A) & 32'h3FF);
        read_bits(1, w);
        chk(w == 0, "R9 R7 counter ended after resumed read", w, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_length_and_order();
        t_retrigger();
        t_bursts();
        t_clear_low();
        t_no_clear_high();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule